// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Front End

This block feeds the output register of a high-rate converter from two parallel input ports. It runs from a single fast clock at the output update rate. Inside, a divide-by-two produces a half-rate "slow" clock. Both input ports are captured on slow-clock rising edges. The output register is updated on fast-clock edges, so that two input words at the slow rate become one output stream at twice that rate.

A 2-bit mode input selects what the block does:

- Interleave: port 2 then port 1 in every slow period.
- Port 1 only: the path behaves as a plain double-buffered register.
- Port 2 only: the same, for the other port.
- The fourth code is rejected.

A reset input realigns the divider, so that the data source can line its word boundaries up with the slow-clock rising edge. A delayed copy of the slow clock is driven out, so the source can use it as a timing reference.

The slow clock is high for the fast period that follows each slow rising edge. The fast edge that ends that period is called the mid edge.

Top module: `dpdac_interleaver`

## Requirements
- R1: In interleave mode (mode code 00), at each slow rising edge both input registers capture their ports. On that same edge, the output takes the port-2 word that was captured at the previous slow rising edge.
- R2: In interleave mode, at the mid edge the output takes the port-1 word captured at the most recent slow rising edge. The output therefore updates twice per slow period.
- R3: In single-port mode (01 selects port 1, 10 selects port 2), at each slow rising edge the output takes the selected port's word captured at the previous slow rising edge. The output is held unchanged at the mid edge.
- R4: Mode code 11 is illegal. While it is in effect, the output holds its last value on every edge and err_o is 1 for that whole slow period. err_o returns to 0 at the first slow rising edge that samples a legal code.
- R5: mode_i is sampled only at slow rising edges. A change between two such edges does not alter the mid-edge behaviour of the current slow period.
- R6: While rst is 1, dac_o, err_o, half_clk_dly_o and both input registers are 0. The first fast edge after rst falls is a slow rising edge.
- R7: half_clk_dly_o is the slow-clock level delayed by DLY fast cycles (DLY defaults to 1). With the default, it reads 0 after a slow rising edge and 1 after the following mid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output update rate |
| rst | input | 1 | Asynchronous active-high reset; realigns the divider |
| mode_i | input | 2 | Mode code: 00 interleave, 01 port 1, 10 port 2, 11 illegal |
| port1_i | input | W | Port 1 data word |
| port2_i | input | W | Port 2 data word |
| dac_o | output | W | Output register driving the converter |
| half_clk_dly_o | output | 1 | Delayed copy of the half-rate clock |
| err_o | output | 1 | Illegal mode flag |

## Verification
The bench builds the block with its defaults: W of 12 and DLY of 1. The 12-bit width lets every word in the stimulus table use a distinct three-nibble pattern, so a word from the wrong port or the wrong slow period cannot be mistaken for the expected one. The single delay stage makes the delayed clock's expected value differ between the sample taken after a slow rising edge and the one taken after a mid edge. That exposes any phase error in the divider, including after the reset asserted in the middle of a slow period.

// File: rtl/dpdac_pkg.sv
package dpdac_pkg;
   typedef enum logic [1:0] {
      MODE_BOTH = 2'b00,
      MODE_P1   = 2'b01,
      MODE_P2   = 2'b10,
      MODE_BAD  = 2'b11
   } mode_e;
endpackage

// File: rtl/dpdac_divider.sv
module dpdac_divider #(
   parameter int DLY = 1
) (
   input  logic clk,
   input  logic rst,
   output logic slow_edge_o,
   output logic half_clk_o,
   output logic half_dly_o
);
   logic phase_q;

   // phase_q high = first half of the slow period; low = next edge is a slow rising edge
   always_ff @(posedge clk or posedge rst) begin
      if (rst) phase_q <= 1'b0;
      else     phase_q <= ~phase_q;
   end

   assign slow_edge_o = ~phase_q;
   assign half_clk_o  = phase_q;

   generate
      if (DLY == 0) begin : g_nodly
         assign half_dly_o = phase_q;
      end else begin : g_dly
         logic [DLY-1:0] sh_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) sh_q <= '0;
            else     sh_q <= DLY'({sh_q, phase_q});
         end
         assign half_dly_o = sh_q[DLY-1];
      end
   endgenerate
endmodule

// File: rtl/dpdac_in_latch.sv
module dpdac_in_latch #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)        q_o <= '0;
      else if (cap_i) q_o <= d_i;
   end
endmodule

// File: rtl/dpdac_out_stage.sv
module dpdac_out_stage
   import dpdac_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         slow_edge_i,
   input  logic [1:0]   mode_i,
   input  logic [W-1:0] p1_q_i,
   input  logic [W-1:0] p2_q_i,
   output logic [1:0]   mode_q_o,
   output logic [W-1:0] dac_o,
   output logic         err_o
);
   mode_e mode_now;
   mode_e mode_q;

   assign mode_now = mode_e'(mode_i);
   assign mode_q_o = mode_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mode_q <= MODE_BOTH;
         dac_o  <= '0;
         err_o  <= 1'b0;
      end else if (slow_edge_i) begin
         mode_q <= mode_now;
         err_o  <= (mode_now == MODE_BAD);
         case (mode_now)
            MODE_BOTH: dac_o <= p2_q_i;
            MODE_P1:   dac_o <= p1_q_i;
            MODE_P2:   dac_o <= p2_q_i;
            default:   dac_o <= dac_o;
         endcase
      end else if (mode_q == MODE_BOTH) begin
         dac_o <= p1_q_i;
      end
   end
endmodule

// File: rtl/dpdac_interleaver.sv
module dpdac_interleaver #(
   parameter int W   = 12,
   parameter int DLY = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   mode_i,
   input  logic [W-1:0] port1_i,
   input  logic [W-1:0] port2_i,
   output logic [W-1:0] dac_o,
   output logic         half_clk_dly_o,
   output logic         err_o
);
   localparam int NPORT = 2;

   generate
      if (W < 1) begin : g_bad_w
         $error("dpdac_interleaver: W must be at least 1");
      end
      if (DLY < 0) begin : g_bad_dly
         $error("dpdac_interleaver: DLY must not be negative");
      end
   endgenerate

   logic                      slow_edge;
   logic                      half_clk;
   logic [1:0]                mode_q;
   logic [NPORT-1:0][W-1:0]   port_d;
   logic [NPORT-1:0][W-1:0]   port_q;
   logic [W-1:0]              p1_q;
   logic [W-1:0]              p2_q;

   assign port_d[0] = port1_i;
   assign port_d[1] = port2_i;
   assign p1_q      = port_q[0];
   assign p2_q      = port_q[1];

   dpdac_divider #(.DLY(DLY)) u_div (
      .clk         (clk),
      .rst         (rst),
      .slow_edge_o (slow_edge),
      .half_clk_o  (half_clk),
      .half_dly_o  (half_clk_dly_o)
   );

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_port
         dpdac_in_latch #(.W(W)) u_lat (
            .clk   (clk),
            .rst   (rst),
            .cap_i (slow_edge),
            .d_i   (port_d[i]),
            .q_o   (port_q[i])
         );
      end
   endgenerate

   dpdac_out_stage #(.W(W)) u_out (
      .clk         (clk),
      .rst         (rst),
      .slow_edge_i (slow_edge),
      .mode_i      (mode_i),
      .p1_q_i      (p1_q),
      .p2_q_i      (p2_q),
      .mode_q_o    (mode_q),
      .dac_o       (dac_o),
      .err_o       (err_o)
   );
endmodule

// File: rtl/dpdac_checker.sv
module dpdac_checker #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst,
   input logic [1:0]   mode_i,
   input logic [W-1:0] dac_o,
   input logic         err_o,
   input logic         half_clk,
   input logic [1:0]   mode_q,
   input logic [W-1:0] p1_q,
   input logic [W-1:0] p2_q
);
   // R1: a slow rising edge in interleave mode emits the held port-2 word
   a_r1_slow_edge_port2: assert property (@(posedge clk) disable iff (rst)
      (!half_clk && mode_i == 2'b00) |=> (dac_o == $past(p2_q)));

   // R2: the mid edge in interleave mode emits the port-1 word
   a_r2_mid_edge_port1: assert property (@(posedge clk) disable iff (rst)
      (half_clk && mode_q == 2'b00) |=> (dac_o == $past(p1_q)));

   // R3 and R5: outside interleave, the mid edge leaves the output alone
   a_r3_single_mid_hold: assert property (@(posedge clk) disable iff (rst)
      (half_clk && mode_q != 2'b00) |=> $stable(dac_o));

   // R4: the output does not move while the error flag is up
   a_r4_illegal_hold: assert property (@(posedge clk) disable iff (rst)
      err_o |-> $stable(dac_o));

   // R6: reset clears the output and the flag
   a_r6_reset_clear: assert property (@(posedge clk)
      rst |-> (dac_o == '0 && !err_o));
endmodule

bind dpdac_interleaver dpdac_checker #(.W(W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mode_i   (mode_i),
   .dac_o    (dac_o),
   .err_o    (err_o),
   .half_clk (half_clk),
   .mode_q   (mode_q),
   .p1_q     (p1_q),
   .p2_q     (p2_q)
);

// File: tb/sim_dpdac_interleaver.sv
module sim_dpdac_interleaver;
   localparam int W  = 12;
   localparam int NV = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   mode_i = 2'b00;
   logic [W-1:0] port1_i = '0;
   logic [W-1:0] port2_i = '0;
   logic [W-1:0] dac_o;
   logic         half_clk_dly_o;
   logic         err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dpdac_interleaver u0 (
      .clk            (clk),
      .rst            (rst),
      .mode_i         (mode_i),
      .port1_i        (port1_i),
      .port2_i        (port2_i),
      .dac_o          (dac_o),
      .half_clk_dly_o (half_clk_dly_o),
      .err_o          (err_o)
   );

   // Each row covers one slow period: mode, port 1, port 2,
   // the expected output after the slow edge and after the mid edge, and the flag.
   localparam logic [1:0]   V_MODE [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd0};
   localparam logic [W-1:0] V_P1   [NV] = '{12'h111, 12'h333, 12'h555, 12'h777, 12'h999,
                                            12'hBBB, 12'hDDD, 12'h123, 12'h789, 12'hFFF};
   localparam logic [W-1:0] V_P2   [NV] = '{12'h222, 12'h444, 12'h666, 12'h888, 12'hAAA,
                                            12'hCCC, 12'hEEE, 12'h456, 12'hABC, 12'h000};
   localparam logic [W-1:0] V_E1   [NV] = '{12'h000, 12'h222, 12'h444, 12'h555, 12'h777,
                                            12'hAAA, 12'hCCC, 12'hCCC, 12'h456, 12'hABC};
   localparam logic [W-1:0] V_E2   [NV] = '{12'h111, 12'h333, 12'h555, 12'h555, 12'h777,
                                            12'hAAA, 12'hCCC, 12'hCCC, 12'h789, 12'hFFF};
   localparam logic         V_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                            1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(2000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R6: reset state
      @(negedge clk);
      @(negedge clk);
      chk("R6 reset dac", dac_o, '0);
      chk("R6 reset err", W'(err_o), '0);
      chk("R6 reset dly", W'(half_clk_dly_o), '0);
      rst = 1'b0;

      // R1 R2 R3 R4 R7: table walk, one slow period per row
      for (int i = 0; i < NV; i++) begin
         mode_i  = V_MODE[i];
         port1_i = V_P1[i];
         port2_i = V_P2[i];
         tick();
         chk($sformatf("R1/R3/R4 slow edge row %0d", i), dac_o, V_E1[i]);
         chk($sformatf("R4 err row %0d", i), W'(err_o), W'(V_ERR[i]));
         chk($sformatf("R7 dly low row %0d", i), W'(half_clk_dly_o), '0);
         tick();
         chk($sformatf("R2/R3/R4 mid edge row %0d", i), dac_o, V_E2[i]);
         chk($sformatf("R4 err mid row %0d", i), W'(err_o), W'(V_ERR[i]));
         chk($sformatf("R7 dly high row %0d", i), W'(half_clk_dly_o), 12'd1);
      end

      // R5: a mode change between slow edges must wait for the next slow edge
      mode_i  = 2'b00;
      port1_i = 12'h135;
      port2_i = 12'h246;
      tick();
      chk("R1 slow edge before mode change", dac_o, 12'h000);
      mode_i = 2'b01;
      tick();
      chk("R5 mid edge keeps interleave", dac_o, 12'h135);
      port1_i = 12'h777;
      port2_i = 12'h888;
      tick();
      chk("R3 port1 mode slow edge", dac_o, 12'h135);
      tick();
      chk("R3 port1 mode mid hold", dac_o, 12'h135);

      // R6: reset in the middle of a slow period realigns the divider
      mode_i  = 2'b00;
      port1_i = 12'h321;
      port2_i = 12'h654;
      tick();
      chk("R1 slow edge before reset", dac_o, 12'h888);
      rst = 1'b1;
      #1;
      chk("R6 async clear dac", dac_o, '0);
      chk("R6 async clear err", W'(err_o), '0);
      tick();
      rst = 1'b0;
      port1_i = 12'h0F0;
      port2_i = 12'h0E0;
      tick();
      chk("R6 first edge is slow edge, latches cleared", dac_o, 12'h000);
      chk("R7 dly after reset slow edge", W'(half_clk_dly_o), '0);
      tick();
      chk("R6 mid edge after reset", dac_o, 12'h0F0);
      chk("R7 dly after reset mid edge", W'(half_clk_dly_o), 12'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule